// File: doc/BRIEF.md
# Miss-Tolerant Memory-Stage Register for a Two-Thread Interleaved Pipeline

This block is the register that sits between the execute stage and the memory stage of an in-order pipeline that interleaves two hardware threads cycle by cycle. Each cycle it accepts one execute-stage result, tagged with its thread number. In the following cycle it presents that result to the memory stage. Loads and stores issue a data-cache request from this register. When the cache answers with a hit, the instruction completes in the same cycle.

When a request misses, the block does not freeze the pipeline. It moves the faulting entry into a shadow slot reserved for its thread and raises that thread's blocked flag, which the fetch scheduler uses to stop the thread's program counter. The other thread keeps passing instructions through the memory stage. When the refill returns, tagged with the thread number, the saved entry re-enters the memory stage. It then completes with the returned data and makes no second cache access. Each thread owns one shadow slot, so both threads may wait on misses at once, and their refills may return in either order.

Top module: `exmem_miss_save`

## Requirements
- R1: While reset is held and on the first cycle after it, `mem_valid`, `dc_req_valid` and every bit of `thread_blocked` are 0.
- R2: An accepted entry with op code 0 (ALU) appears at the MEM output one cycle after it is presented, with `mem_wen`=1 and `mem_data` equal to its result, and it raises no cache request. Op code 3 behaves the same way.
- R3: An accepted entry with op code 1 (load) or 2 (store) drives, one cycle after it is presented, `dc_req_valid`=1 with its thread, `dc_req_addr` equal to its result, `dc_req_we`=1 only for a store, and `dc_req_wdata`. If `dc_hit` is high in that cycle, the entry completes in the same cycle. A load completes with `mem_wen`=1 and `mem_data`=`dc_rdata`. A store completes with `mem_wen`=0 and `mem_data`=0.
- R4: A request whose `dc_hit` is low is a miss. In that cycle the MEM output stays invalid, and the entry is held in its thread's shadow slot. The thread's `thread_blocked` bit goes high on the next cycle.
- R5: An execute-stage entry is dropped, and never reaches the MEM output, if its thread is blocked or if its thread is missing in the same cycle. A blocked thread raises no cache request.
- R6: While one thread is blocked, entries of the other thread keep completing through MEM with the timing of R2 and R3.
- R7: A refill (`dc_resp_valid`) whose `dc_resp_tid` names a thread waiting on an unfilled slot fills that slot. The saved entry then completes exactly once at the MEM output with `mem_data` = `dc_resp_data` (0 for a store) and makes no new cache request.
- R8: A filled entry enters MEM on the first cycle after the refill in which no entry is accepted. A replay therefore takes the memory slot ahead of an entry of its own blocked thread, while an accepted entry of the other thread goes first. The earliest replay output comes two cycles after the refill.
- R9: `thread_blocked[t]` stays high from the cycle after the miss through the cycle in which the replayed entry is at the MEM output, and falls on the next cycle.
- R10: Both threads may be blocked at once. Refills are matched to slots by thread number and may return in either order.
- R11: A refill naming a thread that has no outstanding miss, or whose slot is already filled, has no effect.
- R12: Each thread's entries complete in the order they were accepted, and none is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_valid | input | 1 | Execute-stage entry present |
| ex_tid | input | 1 | Thread of the execute-stage entry |
| ex_op | input | 2 | 0 ALU, 1 load, 2 store, 3 treated as ALU |
| ex_rd | input | 5 | Destination register |
| ex_result | input | 32 | ALU result, or the address for a load or store |
| ex_wdata | input | 32 | Store data |
| dc_req_valid | output | 1 | Data-cache request |
| dc_req_tid | output | 1 | Thread of the request |
| dc_req_we | output | 1 | Request is a store |
| dc_req_addr | output | 32 | Request address |
| dc_req_wdata | output | 32 | Request store data |
| dc_hit | input | 1 | Same-cycle hit; low with a request means miss |
| dc_rdata | input | 32 | Hit load data |
| dc_resp_valid | input | 1 | Refill returned |
| dc_resp_tid | input | 1 | Thread the refill belongs to |
| dc_resp_data | input | 32 | Refill data |
| thread_blocked | output | 2 | Per-thread stall to the fetch scheduler |
| mem_valid | output | 1 | MEM-stage result completes this cycle |
| mem_tid | output | 1 | Thread of the result |
| mem_rd | output | 5 | Destination register |
| mem_wen | output | 1 | Register write enable |
| mem_data | output | 32 | Write-back data |

## Verification
A corrupted shadow slot shows at the MEM output on the first completion of that thread after its refill, either as wrong data or destination or as an entry that never comes back. The drain at the end of the run exposes a lost entry as a non-empty expected queue. A wrong blocked bit is visible at the port on the very next cycle and is compared every cycle. Mis-steering of the replay against a same-cycle execute entry shifts a completion by one cycle or lets a dropped entry through, and the per-thread in-order comparison catches either at the next output of that thread.

// File: rtl/exmem_pkg.sv
package exmem_pkg;

    localparam int XM_DATA_W = 32;
    localparam int XM_REG_W  = 5;

    typedef enum logic [1:0] {
        MOP_ALU   = 2'd0,
        MOP_LOAD  = 2'd1,
        MOP_STORE = 2'd2,
        MOP_RSVD  = 2'd3
    } mem_op_e;

    // One in-flight memory-stage instruction
    typedef struct packed {
        mem_op_e                op;
        logic [XM_REG_W-1:0]    rd;
        logic [XM_DATA_W-1:0]   result;
        logic [XM_DATA_W-1:0]   wdata;
    } xm_entry_t;

    function automatic logic op_uses_cache(input mem_op_e op);
        return (op == MOP_LOAD) || (op == MOP_STORE);
    endfunction

endpackage

// File: rtl/exmem_shadow_slot.sv
module exmem_shadow_slot
    import exmem_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  capture_i,
    input  xm_entry_t             entry_i,
    input  logic                  resp_i,
    input  logic [XM_DATA_W-1:0]  resp_data_i,
    input  logic                  release_i,
    output logic                  occupied_o,
    output logic                  filled_o,
    output xm_entry_t             entry_o,
    output logic [XM_DATA_W-1:0]  data_o
);

    typedef struct packed {
        logic                  occ;
        logic                  fill;
        xm_entry_t             ent;
        logic [XM_DATA_W-1:0]  data;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (capture_i) begin
            slot_d.occ  = 1'b1;
            slot_d.fill = 1'b0;
            slot_d.ent  = entry_i;
        end
        if (resp_i && slot_q.occ && !slot_q.fill) begin
            slot_d.fill = 1'b1;
            slot_d.data = resp_data_i;
        end
        if (release_i) begin
            slot_d.occ  = 1'b0;
            slot_d.fill = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign occupied_o = slot_q.occ;
    assign filled_o   = slot_q.fill;
    assign entry_o    = slot_q.ent;
    assign data_o     = slot_q.data;

endmodule

// File: rtl/exmem_replay_pick.sv
module exmem_replay_pick #(
    parameter int N_REQ = 2,
    localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic [N_REQ-1:0] ready_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    // Fixed priority: the lowest-numbered ready requester wins
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = N_REQ - 1; i >= 0; i--) begin
            if (ready_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/exmem_miss_save.sv
module exmem_miss_save
    import exmem_pkg::*;
#(
    parameter int NUM_THREADS = 2,
    localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ex_valid,
    input  logic [TID_W-1:0]       ex_tid,
    input  logic [1:0]             ex_op,
    input  logic [XM_REG_W-1:0]    ex_rd,
    input  logic [XM_DATA_W-1:0]   ex_result,
    input  logic [XM_DATA_W-1:0]   ex_wdata,
    output logic                   dc_req_valid,
    output logic [TID_W-1:0]       dc_req_tid,
    output logic                   dc_req_we,
    output logic [XM_DATA_W-1:0]   dc_req_addr,
    output logic [XM_DATA_W-1:0]   dc_req_wdata,
    input  logic                   dc_hit,
    input  logic [XM_DATA_W-1:0]   dc_rdata,
    input  logic                   dc_resp_valid,
    input  logic [TID_W-1:0]       dc_resp_tid,
    input  logic [XM_DATA_W-1:0]   dc_resp_data,
    output logic [NUM_THREADS-1:0] thread_blocked,
    output logic                   mem_valid,
    output logic [TID_W-1:0]       mem_tid,
    output logic [XM_REG_W-1:0]    mem_rd,
    output logic                   mem_wen,
    output logic [XM_DATA_W-1:0]   mem_data
);

    typedef struct packed {
        logic                  vld;
        logic [TID_W-1:0]      tid;
        logic                  replay;
        logic [XM_DATA_W-1:0]  fill;
        xm_entry_t             ent;
    } mstage_t;

    mstage_t mem_d, mem_q;

    logic [NUM_THREADS-1:0] slot_occ, slot_fill, capture, resp_hit, release_w, blocked_w;
    xm_entry_t              slot_ent  [NUM_THREADS];
    logic [XM_DATA_W-1:0]   slot_data [NUM_THREADS];
    logic                   pick_any;
    logic [TID_W-1:0]       pick_idx;
    logic                   req_w, miss_w, ex_drop, ex_take;
    xm_entry_t              ex_ent;

    // One shadow slot per thread
    for (genvar g = 0; g < NUM_THREADS; g++) begin : g_slot
        exmem_shadow_slot u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .capture_i   (capture[g]),
            .entry_i     (mem_q.ent),
            .resp_i      (resp_hit[g]),
            .resp_data_i (dc_resp_data),
            .release_i   (release_w[g]),
            .occupied_o  (slot_occ[g]),
            .filled_o    (slot_fill[g]),
            .entry_o     (slot_ent[g]),
            .data_o      (slot_data[g])
        );
    end

    exmem_replay_pick #(.N_REQ(NUM_THREADS)) u_pick (
        .ready_i (slot_fill),
        .any_o   (pick_any),
        .idx_o   (pick_idx)
    );

    always_comb begin
        ex_ent.op     = mem_op_e'(ex_op);
        ex_ent.rd     = ex_rd;
        ex_ent.result = ex_result;
        ex_ent.wdata  = ex_wdata;

        req_w  = mem_q.vld && !mem_q.replay && op_uses_cache(mem_q.ent.op);
        miss_w = req_w && !dc_hit;

        release_w = '0;
        ex_drop   = 1'b1;
        for (int t = 0; t < NUM_THREADS; t++) begin
            capture[t]   = miss_w && (mem_q.tid == TID_W'(t));
            resp_hit[t]  = dc_resp_valid && (dc_resp_tid == TID_W'(t));
            blocked_w[t] = slot_occ[t] ||
                           (mem_q.vld && mem_q.replay && (mem_q.tid == TID_W'(t)));
            if (ex_tid == TID_W'(t)) ex_drop = blocked_w[t] || capture[t];
        end
        ex_take = ex_valid && !ex_drop;

        mem_d = '0;
        if (pick_any && !ex_take) begin
            mem_d.vld    = 1'b1;
            mem_d.tid    = pick_idx;
            mem_d.replay = 1'b1;
            mem_d.fill   = slot_data[pick_idx];
            mem_d.ent    = slot_ent[pick_idx];
            release_w[pick_idx] = 1'b1;
        end else if (ex_take) begin
            mem_d.vld = 1'b1;
            mem_d.tid = ex_tid;
            mem_d.ent = ex_ent;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign dc_req_valid   = req_w;
    assign dc_req_tid     = mem_q.tid;
    assign dc_req_we      = (mem_q.ent.op == MOP_STORE);
    assign dc_req_addr    = mem_q.ent.result;
    assign dc_req_wdata   = mem_q.ent.wdata;
    assign thread_blocked = blocked_w;

    assign mem_valid = mem_q.vld && !miss_w;
    assign mem_tid   = mem_q.tid;
    assign mem_rd    = mem_q.ent.rd;
    assign mem_wen   = (mem_q.ent.op != MOP_STORE);
    assign mem_data  = (mem_q.ent.op == MOP_LOAD)  ? (mem_q.replay ? mem_q.fill : dc_rdata) :
                       (mem_q.ent.op == MOP_STORE) ? '0 : mem_q.ent.result;

endmodule

// File: rtl/exmem_miss_save_chk.sv
module exmem_miss_save_chk #(
    parameter int NUM_THREADS = 2,
    localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   dc_req_valid,
    input logic [TID_W-1:0]       dc_req_tid,
    input logic                   dc_hit,
    input logic                   mem_valid,
    input logic [TID_W-1:0]       mem_tid,
    input logic [NUM_THREADS-1:0] thread_blocked
);

    // R3
    req_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dc_req_valid |-> (mem_valid == dc_hit));

    // R5
    blocked_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dc_req_valid |-> !thread_blocked[dc_req_tid]);

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        // R4
        block_after_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(thread_blocked[t]) |->
                $past(dc_req_valid && !dc_hit && (dc_req_tid == TID_W'(t))));

        // R4
        miss_then_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (dc_req_valid && !dc_hit && (dc_req_tid == TID_W'(t))) |=> thread_blocked[t]);

        // R9
        unblock_on_replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(thread_blocked[t]) |-> $past(mem_valid && (mem_tid == TID_W'(t))));
    end

endmodule

bind exmem_miss_save exmem_miss_save_chk #(.NUM_THREADS(NUM_THREADS)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .dc_req_valid   (dc_req_valid),
    .dc_req_tid     (dc_req_tid),
    .dc_hit         (dc_hit),
    .mem_valid      (mem_valid),
    .mem_tid        (mem_tid),
    .thread_blocked (thread_blocked)
);

// File: tb/exmem_miss_save_bench.sv
module exmem_miss_save_bench;

    localparam int NT = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ex_valid;
    logic [0:0]  ex_tid;
    logic [1:0]  ex_op;
    logic [4:0]  ex_rd;
    logic [31:0] ex_result, ex_wdata;
    logic        dc_req_valid;
    logic [0:0]  dc_req_tid;
    logic        dc_req_we;
    logic [31:0] dc_req_addr, dc_req_wdata;
    logic        dc_hit;
    logic [31:0] dc_rdata;
    logic        dc_resp_valid;
    logic [0:0]  dc_resp_tid;
    logic [31:0] dc_resp_data;
    logic [1:0]  thread_blocked;
    logic        mem_valid;
    logic [0:0]  mem_tid;
    logic [4:0]  mem_rd;
    logic        mem_wen;
    logic [31:0] mem_data;

    always #5 clk = ~clk;

    exmem_miss_save #(.NUM_THREADS(NT)) u_exmem_miss_save (
        .clk(clk), .rst_n(rst_n),
        .ex_valid(ex_valid), .ex_tid(ex_tid), .ex_op(ex_op), .ex_rd(ex_rd),
        .ex_result(ex_result), .ex_wdata(ex_wdata),
        .dc_req_valid(dc_req_valid), .dc_req_tid(dc_req_tid), .dc_req_we(dc_req_we),
        .dc_req_addr(dc_req_addr), .dc_req_wdata(dc_req_wdata),
        .dc_hit(dc_hit), .dc_rdata(dc_rdata),
        .dc_resp_valid(dc_resp_valid), .dc_resp_tid(dc_resp_tid), .dc_resp_data(dc_resp_data),
        .thread_blocked(thread_blocked),
        .mem_valid(mem_valid), .mem_tid(mem_tid), .mem_rd(mem_rd),
        .mem_wen(mem_wen), .mem_data(mem_data)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // Expected per-thread completion queues
    logic [1:0]  q_op  [NT][64];
    logic [4:0]  q_rd  [NT][64];
    logic [31:0] q_res [NT][64];
    logic [31:0] q_wd  [NT][64];
    int          q_head [NT];
    int          q_tail [NT];

    bit          waiting   [NT];
    bit          responded [NT];
    int          lat       [NT];
    logic [31:0] miss_addr [NT];
    int          fixed_lat = 0;
    int          miss_pct  = 30;
    bit          last_out_v;
    int          last_out_t;
    int          first_replay_t;

    function automatic logic [31:0] ld_val(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input bit v, input int t, input logic [1:0] op, input logic [4:0] rd,
                         input logic [31:0] res, input logic [31:0] wd);
        ex_valid  = v;
        ex_tid    = 1'(t);
        ex_op     = op;
        ex_rd     = rd;
        ex_result = res;
        ex_wdata  = wd;
    endtask

    // hitmode: 0 random, 1 force hit, 2 force miss. spur: thread for a stray refill, -1 none
    task automatic step(input int hitmode, input int spur);
        int  rt, h, et, ot;
        bit  miss, sent;
        logic [31:0] exp_d;
        // R9 / R4: blocked flag per thread
        for (int t = 0; t < NT; t++)
            check(thread_blocked[t] == waiting[t], "R9 blocked flag", 32'(thread_blocked[t]), 32'(waiting[t]));
        dc_hit   = 1'b0;
        dc_rdata = '0;
        if (dc_req_valid) begin
            rt = int'(dc_req_tid);
            h  = q_head[rt];
            check(q_head[rt] != q_tail[rt], "R3 request with no pending entry", 32'(rt), 32'(rt));
            check(!waiting[rt], "R5 request from blocked thread", 32'(rt), 32'(rt));
            check(dc_req_addr == q_res[rt][h % 64], "R3 request address", dc_req_addr, q_res[rt][h % 64]);
            check(dc_req_we == (q_op[rt][h % 64] == 2'd2), "R3 request write flag",
                  32'(dc_req_we), 32'(q_op[rt][h % 64] == 2'd2));
            if (q_op[rt][h % 64] == 2'd2)
                check(dc_req_wdata == q_wd[rt][h % 64], "R3 request store data", dc_req_wdata, q_wd[rt][h % 64]);
            miss = (hitmode == 2) ? 1'b1 : (hitmode == 1) ? 1'b0 : ($urandom_range(99) < miss_pct);
            if (!miss) begin
                dc_hit   = 1'b1;
                dc_rdata = ld_val(dc_req_addr);
            end else begin
                waiting[rt]   = 1'b1;
                responded[rt] = 1'b0;
                lat[rt]       = (fixed_lat != 0) ? fixed_lat : $urandom_range(9, 6);
                miss_addr[rt] = dc_req_addr;
            end
        end
        dc_resp_valid = 1'b0;
        dc_resp_tid   = '0;
        dc_resp_data  = '0;
        sent = 1'b0;
        for (int t = 0; t < NT; t++) begin
            if (lat[t] == 1 && !sent) begin
                dc_resp_valid = 1'b1;
                dc_resp_tid   = 1'(t);
                dc_resp_data  = ld_val(miss_addr[t]);
                lat[t]        = 0;
                responded[t]  = 1'b1;
                sent          = 1'b1;
            end else if (lat[t] > 1) begin
                lat[t]--;
            end
        end
        if (!sent && spur >= 0 && !(waiting[spur] && !responded[spur])) begin
            dc_resp_valid = 1'b1;
            dc_resp_tid   = 1'(spur);
            dc_resp_data  = 32'hDEAD0000;
        end
        et = int'(ex_tid);
        if (ex_valid && !waiting[et]) begin
            q_op [et][q_tail[et] % 64] = ex_op;
            q_rd [et][q_tail[et] % 64] = ex_rd;
            q_res[et][q_tail[et] % 64] = ex_result;
            q_wd [et][q_tail[et] % 64] = ex_wdata;
            q_tail[et]++;
        end
        #1;
        last_out_v = mem_valid;
        last_out_t = int'(mem_tid);
        if (mem_valid) begin
            ot = int'(mem_tid);
            if (q_head[ot] == q_tail[ot]) begin
                check(1'b0, "R12 unexpected completion", 32'(ot), 32'hFFFFFFFF);
            end else begin
                h = q_head[ot] % 64;
                exp_d = (q_op[ot][h] == 2'd1) ? ld_val(q_res[ot][h]) :
                        (q_op[ot][h] == 2'd2) ? 32'd0 : q_res[ot][h];
                if (waiting[ot]) begin
                    check(responded[ot], "R7 replay before refill", 32'(responded[ot]), 32'd1);
                    check(mem_data == exp_d, "R7 replay data", mem_data, exp_d);
                end else if (q_op[ot][h] == 2'd0) begin
                    check(mem_data == exp_d, "R2 ALU data", mem_data, exp_d);
                end else begin
                    check(mem_data == exp_d, "R3 hit data", mem_data, exp_d);
                end
                check(mem_rd == q_rd[ot][h], "R12 destination order", 32'(mem_rd), 32'(q_rd[ot][h]));
                check(mem_wen == (q_op[ot][h] != 2'd2), "R3 write enable",
                      32'(mem_wen), 32'(q_op[ot][h] != 2'd2));
                q_head[ot]++;
                if (waiting[ot]) begin
                    if (first_replay_t < 0) first_replay_t = ot;
                    waiting[ot] = 1'b0;
                end
            end
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        drive(1'b0, 0, 2'd0, 5'd0, 32'd0, 32'd0);
        for (int i = 0; i < n; i++) step(0, -1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        for (int t = 0; t < NT; t++) begin
            q_head[t] = 0; q_tail[t] = 0; waiting[t] = 0; responded[t] = 0; lat[t] = 0;
            miss_addr[t] = '0;
        end
        rst_n = 1'b0;
        drive(1'b0, 0, 2'd0, 5'd0, 32'd0, 32'd0);
        dc_hit = 0; dc_rdata = 0; dc_resp_valid = 0; dc_resp_tid = 0; dc_resp_data = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(mem_valid == 1'b0, "R1 mem_valid in reset", 32'(mem_valid), 32'd0);
        check(dc_req_valid == 1'b0, "R1 dc_req_valid in reset", 32'(dc_req_valid), 32'd0);
        check(thread_blocked == 2'b00, "R1 blocked in reset", 32'(thread_blocked), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_valid == 1'b0 && thread_blocked == 2'b00, "R1 state after reset",
              32'({mem_valid, thread_blocked}), 32'd0);

        // R2: ALU passes with one cycle delay
        drive(1'b1, 0, 2'd0, 5'd3, 32'h1234_5678, 32'd0); step(0, -1);
        drive(1'b0, 0, 2'd0, 5'd0, 32'd0, 32'd0);         step(0, -1);
        check(last_out_v && last_out_t == 0, "R2 ALU completes next cycle", 32'(last_out_v), 32'd1);

        // R8: replay beats an entry of its own blocked thread
        fixed_lat = 3;
        drive(1'b1, 0, 2'd1, 5'd7, 32'h0000_0100, 32'd0); step(0, -1);
        drive(1'b1, 1, 2'd0, 5'd2, 32'h0000_0055, 32'd0); step(2, -1);
        idle(1);
        drive(1'b0, 0, 2'd0, 5'd0, 32'd0, 32'd0);         step(0, -1);
        drive(1'b1, 0, 2'd0, 5'd9, 32'h0000_0AAA, 32'd0); step(0, -1);
        drive(1'b0, 0, 2'd0, 5'd0, 32'd0, 32'd0);         step(0, -1);
        check(last_out_v && last_out_t == 0, "R8 replay takes own slot", 32'(last_out_t), 32'd0);
        step(0, -1);
        check(!last_out_v, "R5 blocked entry dropped", 32'(last_out_v), 32'd0);

        // R8: other thread's entry goes before the replay
        drive(1'b1, 0, 2'd1, 5'd4, 32'h0000_0200, 32'd0); step(0, -1);
        drive(1'b0, 0, 2'd0, 5'd0, 32'd0, 32'd0);         step(2, -1);
        idle(1);
        step(0, -1);
        drive(1'b1, 1, 2'd0, 5'd6, 32'h0000_0077, 32'd0); step(0, -1);
        drive(1'b0, 0, 2'd0, 5'd0, 32'd0, 32'd0);         step(0, -1);
        check(last_out_v && last_out_t == 1, "R8 other thread first", 32'(last_out_t), 32'd1);
        step(0, -1);
        check(last_out_v && last_out_t == 0, "R8 replay one cycle later", 32'(last_out_t), 32'd0);
        idle(2);

        // R10: both threads miss, refills return in reverse order
        first_replay_t = -1;
        fixed_lat = 8;
        drive(1'b1, 0, 2'd1, 5'd1, 32'h0000_0300, 32'd0); step(0, -1);
        drive(1'b1, 1, 2'd2, 5'd0, 32'h0000_0400, 32'h0BAD_F00D); step(2, -1);
        fixed_lat = 2;
        drive(1'b0, 0, 2'd0, 5'd0, 32'd0, 32'd0); step(2, -1);
        check(waiting[0] && waiting[1], "R10 both threads waiting", 32'({waiting[1], waiting[0]}), 32'd3);
        idle(12);
        check(first_replay_t == 1, "R10 refill matched by thread", 32'(first_replay_t), 32'd1);

        // R11: stray refills leave slots untouched
        fixed_lat = 0;
        step(0, 1);
        step(0, 0);
        check(!last_out_v, "R11 stray refill no output", 32'(last_out_v), 32'd0);
        drive(1'b1, 1, 2'd1, 5'd5, 32'h0000_0500, 32'd0); step(0, -1);
        drive(1'b0, 0, 2'd0, 5'd0, 32'd0, 32'd0);         step(2, -1);
        idle(12);

        // Random interleaved traffic (R6, R7, R12)
        for (int i = 0; i < 4000; i++) begin
            drive($urandom_range(9) < 8, i % 2, 2'($urandom_range(2)), 5'($urandom),
                  $urandom, $urandom);
            step(0, ($urandom_range(49) == 0) ? int'($urandom_range(1)) : -1);
        end
        idle(30);

        // R12: nothing lost
        for (int t = 0; t < NT; t++) begin
            check(q_head[t] == q_tail[t], "R12 all entries completed", 32'(q_tail[t] - q_head[t]), 32'd0);
            check(!waiting[t], "R7 no thread left waiting", 32'(waiting[t]), 32'd0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule